// File: doc/BRIEF.md
# Sample Input Capture and Formatter

This block sits at the front of a receive channel. On each clock it looks at one 17-bit parallel sample bus and an active-low enable. It turns every word it accepts into a 24-bit signed fixed-point sample for the mixer that follows. The bus can carry one of two formats. The fixed format is a plain 16-bit two's-complement value. The floating format is a two's-complement mantissa plus a small exponent, and it needs the extra bit that sits below the least significant bit.

The enable works in one of two capture modes. In gated mode a word is accepted on every clock in which the enable is low, and nothing is produced on other clocks. In interpolated mode every accepted word is followed by zero-valued samples on the clocks where the enable is high, so the output rate stays constant. A sync input can clear the capture history, and configuration decides whether it is honoured.

The output is a stream with a valid strobe and no ready. The source is a free-running sampled bus and cannot be held off, so the block applies no back-pressure. The consumer must take each word in the cycle in which `out_valid` is high.

Top module: `smp_ingest`

## Requirements
- R1: While `rst_n` is low, and after the first clock edge of reset, `out_valid` is 0 and `out_sample` is 0.
- R2: In fixed format (`cfg_float`=0), bus bits [16:1] form a 16-bit two's-complement value. That value goes to `out_sample[23:8]`, bits [7:0] are zero, and bus bit 0 (the sub-LSB) has no effect on the result.
- R3: In floating format (`cfg_float`=1), bus bits [16:3] are a 14-bit two's-complement mantissa and bits [2:0] are an unsigned exponent. The output is the mantissa sign-extended to 24 bits and shifted left by the exponent.
- R4: A word is accepted on a rising edge where `en_n` is 0. Its converted value appears with `out_valid`=1 right after that same edge, for exactly one cycle.
- R5: In gated mode (`cfg_interp`=0), an edge with `en_n`=1 gives `out_valid`=0 after it.
- R6: In interpolated mode (`cfg_interp`=1), once a word has been accepted, each later edge with `en_n`=1 gives `out_valid`=1 and `out_sample`=0.
- R7: In interpolated mode no zero-fill is produced until the first word after reset, or after an honoured sync, has been accepted.
- R8: When `cfg_sync_en`=1, an edge with `sync_in`=1 gives `out_valid`=0 after it, even if `en_n` is 0. It also clears the capture history, so zero-fill stops until the next accepted word.
- R9: When `cfg_sync_en`=0, `sync_in` has no effect on acceptance or zero-fill.
- R10: `out_sample` is 0 in every cycle where `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_bus | input | 17 | Sample bus; bit 0 is the sub-LSB, bit 16 the MSB |
| en_n | input | 1 | Sample enable, active low |
| sync_in | input | 1 | Channel sync, active high |
| cfg_float | input | 1 | 0 = fixed format, 1 = mantissa/exponent format |
| cfg_interp | input | 1 | 0 = gated mode, 1 = interpolated mode |
| cfg_sync_en | input | 1 | 1 = sync_in is honoured |
| out_sample | output | 24 | Converted signed sample |
| out_valid | output | 1 | One-cycle strobe marking a valid out_sample |

## Verification
The bench builds the block with its default parameters: a 17-bit bus, a 3-bit exponent and a 24-bit result. With these values all eight exponent shifts, both mantissa extremes and a strided sweep of the whole mantissa and fixed ranges are cheap to cover, and the sub-LSB is toggled throughout. The small width also lets the bench predict every result with plain integer arithmetic. Short directed sequences then drive the cadence state through reset, priming, an honoured sync in the middle of a zero-fill run and an ignored sync.

// File: rtl/smp_ingest_pkg.sv
package smp_ingest_pkg;
  typedef enum logic {FMT_FIXED = 1'b0, FMT_FLOAT = 1'b1} fmt_e;
  typedef enum logic {CAP_GATED = 1'b0, CAP_INTERP = 1'b1} cap_e;
endpackage

// File: rtl/smp_fmt_conv.sv
module smp_fmt_conv
  import smp_ingest_pkg::*;
#(
  parameter int BUS_W = 17,
  parameter int EXP_W = 3,
  parameter int OUT_W = 24
) (
  input  logic [BUS_W-1:0] raw_i,
  input  fmt_e             fmt_i,
  output logic [OUT_W-1:0] conv_o
);
  localparam int FIX_W  = BUS_W - 1;
  localparam int MANT_W = BUS_W - EXP_W;
  localparam int EXT_W  = OUT_W - MANT_W;

  logic [FIX_W-1:0]  fix_field;
  logic [MANT_W-1:0] mant_field;
  logic [EXP_W-1:0]  exp_field;
  logic [OUT_W-1:0]  fix_val;
  logic [OUT_W-1:0]  stage [EXP_W+1];

  assign fix_field  = raw_i[BUS_W-1:1];
  assign mant_field = raw_i[BUS_W-1:EXP_W];
  assign exp_field  = raw_i[EXP_W-1:0];

  // fixed word left-justified, padding only when the result is wider
  generate
    if (OUT_W > FIX_W) begin : g_pad
      assign fix_val = {fix_field, {(OUT_W-FIX_W){1'b0}}};
    end else begin : g_nopad
      assign fix_val = fix_field[FIX_W-1 -: OUT_W];
    end
  endgenerate

  // logarithmic shifter, one stage per exponent bit
  assign stage[0] = {{EXT_W{mant_field[MANT_W-1]}}, mant_field};
  generate
    for (genvar s = 0; s < EXP_W; s++) begin : g_shift
      assign stage[s+1] = exp_field[s] ? (stage[s] << (1 << s)) : stage[s];
    end
  endgenerate

  assign conv_o = (fmt_i == FMT_FLOAT) ? stage[EXP_W] : fix_val;
endmodule

// File: rtl/smp_cadence_ctl.sv
module smp_cadence_ctl
  import smp_ingest_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  input  cap_e mode_i,
  input  logic sync_hit_i,
  output logic emit_data_o,
  output logic emit_zero_o
);
  logic primed_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          primed_q <= 1'b0;
    else if (sync_hit_i) primed_q <= 1'b0;
    else if (take_i)     primed_q <= 1'b1;
  end

  assign emit_data_o = take_i && !sync_hit_i;
  assign emit_zero_o = (mode_i == CAP_INTERP) && primed_q && !take_i && !sync_hit_i;

  // R8
  primed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hit_i |=> !primed_q);
endmodule

// File: rtl/smp_ingest.sv
module smp_ingest
  import smp_ingest_pkg::*;
#(
  parameter int BUS_W = 17,
  parameter int EXP_W = 3,
  parameter int OUT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] in_bus,
  input  logic             en_n,
  input  logic             sync_in,
  input  logic             cfg_float,
  input  logic             cfg_interp,
  input  logic             cfg_sync_en,
  output logic [OUT_W-1:0] out_sample,
  output logic             out_valid
);
  localparam int FIX_W = BUS_W - 1;

  logic             take;
  logic             sync_hit;
  logic             emit_data;
  logic             emit_zero;
  logic [OUT_W-1:0] conv;
  fmt_e             fmt;
  cap_e             mode;

  assign take     = !en_n;
  assign sync_hit = cfg_sync_en && sync_in;
  assign fmt      = cfg_float ? FMT_FLOAT : FMT_FIXED;
  assign mode     = cfg_interp ? CAP_INTERP : CAP_GATED;

  smp_fmt_conv #(.BUS_W(BUS_W), .EXP_W(EXP_W), .OUT_W(OUT_W)) i_conv (
    .raw_i  (in_bus),
    .fmt_i  (fmt),
    .conv_o (conv)
  );

  smp_cadence_ctl i_cadence (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (take),
    .mode_i      (mode),
    .sync_hit_i  (sync_hit),
    .emit_data_o (emit_data),
    .emit_zero_o (emit_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else if (emit_data) begin
      out_valid  <= 1'b1;
      out_sample <= conv;
    end else if (emit_zero) begin
      out_valid  <= 1'b1;
      out_sample <= '0;
    end else begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end
  end

  // R4
  capture_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && !(cfg_sync_en && sync_in)) |=> out_valid);

  // R5
  gated_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n && !cfg_interp) |=> !out_valid);

  // R8
  sync_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sync_en && sync_in) |=> !out_valid);

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_sample == '0));

  // R2
  fixed_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && !cfg_float && !(cfg_sync_en && sync_in))
      |=> (out_sample[OUT_W-1 -: FIX_W] == $past(in_bus[BUS_W-1:1])));

  // R3
  float_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && cfg_float && !(cfg_sync_en && sync_in) && (in_bus[BUS_W-1:EXP_W] != '0))
      |=> (out_sample[OUT_W-1] == $past(in_bus[BUS_W-1])));

  // R6
  interp_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_interp && !en_n && !(cfg_sync_en && sync_in)) ##1
    (cfg_interp && en_n && !(cfg_sync_en && sync_in))
      |=> (out_valid && out_sample == '0));
endmodule

// File: tb/test_smp_ingest.sv
module test_smp_ingest;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [16:0] in_bus;
  logic        en_n, sync_in, cfg_float, cfg_interp, cfg_sync_en;
  logic [23:0] out_sample;
  logic        out_valid;
  int          n_chk = 0;
  int          n_err = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  smp_ingest i_smp_ingest (
    .clk(clk), .rst_n(rst_n), .in_bus(in_bus), .en_n(en_n), .sync_in(sync_in),
    .cfg_float(cfg_float), .cfg_interp(cfg_interp), .cfg_sync_en(cfg_sync_en),
    .out_sample(out_sample), .out_valid(out_valid)
  );

  task automatic chk(input string req, input logic ev, input logic [23:0] es);
    n_chk++;
    if (out_valid !== ev || out_sample !== es) begin
      n_err++;
      $display("FAIL %s: got valid=%b sample=%h, expected valid=%b sample=%h",
               req, out_valid, out_sample, ev, es);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, check at the next falling edge
  task automatic step(input logic en, input logic [16:0] bus, input logic sy,
                      input string req, input logic ev, input logic [23:0] es);
    en_n = en; in_bus = bus; sync_in = sy;
    @(negedge clk);
    chk(req, ev, es);
  endtask

  function automatic logic [23:0] flt_exp(input int m, input int e);
    int v;
    v = m * (1 << e);
    return v[23:0];
  endfunction

  function automatic logic [16:0] flt_bus(input int m, input int e);
    logic [13:0] mm;
    logic [2:0]  ee;
    mm = m[13:0];
    ee = e[2:0];
    return {mm, ee};
  endfunction

  task automatic flt_one(input int m, input int e);
    step(1'b0, flt_bus(m, e), 1'b0, "R3", 1'b1, flt_exp(m, e));
  endtask

  initial begin
    rst_n = 1'b0; en_n = 1'b1; in_bus = '0; sync_in = 1'b0;
    cfg_float = 1'b0; cfg_interp = 1'b0; cfg_sync_en = 1'b0;
    @(negedge clk);
    // R1: reset state, even with an active enable
    step(1'b0, 17'h1ffff, 1'b0, "R1", 1'b0, 24'h0);
    step(1'b0, 17'h0aaaa, 1'b0, "R1", 1'b0, 24'h0);
    rst_n = 1'b1;

    // R7: interpolated mode, nothing captured yet -> silence
    cfg_interp = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b1, '0, 1'b0, "R7", 1'b0, 24'h0);
    cfg_interp = 1'b0;

    // R3 float sweep across every exponent, with mantissa extremes
    cfg_float = 1'b1;
    for (int e = 0; e < 8; e++) begin
      for (int m = -8192; m < 8192; m += 61) flt_one(m, e);
      flt_one(8191, e);
      flt_one(-1, e);
      flt_one(1, e);
    end
    // R4: one-cycle strobe after a capture, then gated idle
    step(1'b0, flt_bus(-8192, 7), 1'b0, "R4", 1'b1, 24'hf00000);
    step(1'b1, flt_bus(5, 1), 1'b0, "R4", 1'b0, 24'h0);

    // R5 / R10: gated idle produces nothing and a zero word
    for (int i = 0; i < 3; i++) step(1'b1, 17'h1ffff, 1'b0, "R5", 1'b0, 24'h0);
    step(1'b1, 17'h00001, 1'b0, "R10", 1'b0, 24'h0);

    // R2 fixed sweep, sub-LSB toggled
    cfg_float = 1'b0;
    for (int v = -32768; v < 32768; v += 97) begin
      logic [15:0] vv;
      vv = v[15:0];
      step(1'b0, {vv, vv[0] ^ vv[3]}, 1'b0, "R2", 1'b1, {vv, 8'h00});
    end
    step(1'b0, {16'h7fff, 1'b1}, 1'b0, "R2", 1'b1, 24'h7fff00);
    step(1'b0, {16'h8000, 1'b1}, 1'b0, "R2", 1'b1, 24'h800000);
    step(1'b0, {16'h0000, 1'b1}, 1'b0, "R2", 1'b1, 24'h000000);

    // R6: interpolated mode zero-fill
    cfg_interp = 1'b1;
    step(1'b0, {16'h1234, 1'b0}, 1'b0, "R6", 1'b1, 24'h123400);
    for (int i = 0; i < 3; i++) step(1'b1, 17'h1ffff, 1'b0, "R6", 1'b1, 24'h0);
    step(1'b0, {16'hfedc, 1'b1}, 1'b0, "R6", 1'b1, 24'hfedc00);
    step(1'b1, '0, 1'b0, "R6", 1'b1, 24'h0);

    // R8: honoured sync drops the word and clears the history
    cfg_sync_en = 1'b1;
    step(1'b0, {16'h4444, 1'b0}, 1'b1, "R8", 1'b0, 24'h0);
    step(1'b1, '0, 1'b0, "R8", 1'b0, 24'h0);
    step(1'b1, '0, 1'b0, "R7", 1'b0, 24'h0);
    step(1'b0, {16'h0101, 1'b0}, 1'b0, "R8", 1'b1, 24'h010100);
    step(1'b1, '0, 1'b0, "R8", 1'b1, 24'h0);
    step(1'b1, '0, 1'b1, "R8", 1'b0, 24'h0);
    step(1'b1, '0, 1'b0, "R8", 1'b0, 24'h0);

    // R9: sync ignored when not enabled
    cfg_sync_en = 1'b0;
    step(1'b0, {16'h2222, 1'b0}, 1'b1, "R9", 1'b1, 24'h222200);
    step(1'b1, '0, 1'b1, "R9", 1'b1, 24'h0);
    step(1'b1, '0, 1'b0, "R9", 1'b1, 24'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got running, expected finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule